// File: doc/BRIEF.md
# Linked-Descriptor Memory-to-Stream DMA Engine

This engine walks a singly linked chain of data descriptors held in memory and sends each described buffer, one byte per transfer, to a stream consumer with a valid/ready handshake. Every descriptor is four 32-bit words. The engine fetches them through a simple word request/acknowledge memory port. It streams the bytes from the buffer start address up to the exclusive end address, then writes the flags word back to memory. Next it either follows the link to the next descriptor or halts when the descriptor marks the end of the chain.

When the chain ends, the engine reads the flags word of the enclosing context record and writes it back with the disable bit set. The engine then waits. Software may edit the halted descriptor and issue a continue. The engine fetches that descriptor again. If the end-of-chain mark has been cleared, the engine moves to the linked descriptor and resumes streaming. A level-sensitive enable and stop pair gates both start and continue. An interrupt latch records completed descriptors that asked for one.

Top module: `dsd_engine`

## Requirements
- R1: After reset, busy_o, running_o, eol_o, intr_o, st_valid_o and mem_req_o are all 0.
- R2: A descriptor at address D is four words: link at D+0, buffer start at D+4, flags at D+8 and exclusive buffer end at D+12. The bytes from start to end-1 leave on the stream in rising address order. The byte at address a is taken from bits 8*(a mod 4) and up of the word at a with its two low bits cleared.
- R3: A buffer whose start equals its end sends no byte, and its descriptor still completes normally.
- R4: When flags bit 3 is set, st_last_o is 1 with the final byte of that buffer and with no other byte. When bit 3 is clear, st_last_o stays 0.
- R5: When a buffer with flags bit 4 set completes, intr_o becomes 1 and stays 1 until a pulse on intr_ack_i. A buffer with bit 4 clear does not set intr_o.
- R6: Every completed descriptor has its flags word written back to D+8.
- R7: When flags bit 0 is clear, the next descriptor is fetched from the link address, and its buffer follows without a gap in the byte order.
- R8: When flags bit 0 is set, eol_o becomes 1 and the word at context address C+4 is read and written back with bit 15 set and its other bits unchanged. The engine then goes idle with running_o still 1.
- R9: buf_ptr_o is loaded with the buffer start when a descriptor is fetched. It is then updated after every BURST_MAX bytes of that buffer and when the buffer end is reached.
- R10: While st_valid_o is 1 and st_ready_i is 0, the byte, its last flag and the valid stay unchanged. A memory request keeps its address, direction and data until it is acknowledged. No memory request is made while a byte is offered.
- R11: cont_i is ignored unless enable_i is 1, stop_i is 0, running_o is 1 and the engine is halted at the end of the chain. An accepted continue fetches the halted descriptor again, and if bit 0 is still set the engine halts again with no byte sent.
- R12: An accepted continue that finds bit 0 cleared clears eol_o, fetches the linked descriptor and streams it.
- R13: start_i loads the head and context addresses, clears eol_o and sets running_o only when enable_i is 1 and stop_i is 0. enable_i at 0 or stop_i at 1 clears running_o on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Channel enable level |
| stop_i | input | 1 | Channel stop level |
| start_i | input | 1 | Start pulse |
| cont_i | input | 1 | Continue pulse |
| head_ptr_i | input | AW | Address of the first descriptor |
| ctx_ptr_i | input | AW | Address of the context record |
| intr_ack_i | input | 1 | Clears the interrupt latch |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | 1 for a write, 0 for a read |
| mem_addr_o | output | AW | Word address (byte units, low bits 0) |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | One-cycle acknowledge |
| mem_rdata_i | input | 32 | Read data, valid with the acknowledge |
| st_valid_o | output | 1 | Stream byte valid |
| st_data_o | output | 8 | Stream byte |
| st_last_o | output | 1 | Final byte of an end-of-packet buffer |
| st_ready_i | input | 1 | Stream consumer ready |
| busy_o | output | 1 | Engine is not idle |
| running_o | output | 1 | Channel running state |
| eol_o | output | 1 | Channel halted at end of chain |
| intr_o | output | 1 | Interrupt latch |
| buf_ptr_o | output | AW | Mirror of the buffer pointer |
| desc_ptr_o | output | AW | Address of the current descriptor |

## Verification
A sweep covers every start offset within a word against buffer lengths from zero to nine, with a small burst limit. This separates byte-lane selection errors, off-by-one end detection, empty-buffer handling and burst-boundary mirror updates. A ready signal that stalls pseudo-randomly on half of the sweep shows whether the handshake loses or repeats bytes. A three-link chain containing an empty middle buffer tests link following and write-back counts. A scenario with continue under stop, continue with the mark still set and continue with the mark cleared tells the resume rule apart from a plain restart.

// File: rtl/dsd_pkg.sv
package dsd_pkg;
  // flag bit positions inside the descriptor flags word
  localparam int FL_EOL  = 0;
  localparam int FL_OEOP = 3;
  localparam int FL_INTR = 4;
  // disable bit inside the context flags word
  localparam int CTX_DIS = 15;
  // word index of the context flags word
  localparam int CTX_FLAGS_WORD = 1;
  localparam int DESC_WORDS = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CHECK, S_RD, S_PUSH, S_WB, S_CTX_RD, S_CTX_WR
  } dsd_state_e;
endpackage

// File: rtl/dsd_lane_sel.sv
module dsd_lane_sel #(
  parameter int LANES = 4,
  localparam int SW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [8*LANES-1:0] word_i,
  input  logic [SW-1:0]      sel_i,
  output logic [7:0]         byte_o
);
  logic [7:0] lane [LANES];
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = word_i[8*g +: 8];
  end
  assign byte_o = lane[sel_i];
endmodule

// File: rtl/dsd_burst_ctr.sv
module dsd_burst_ctr #(
  parameter int BURST_MAX = 2048,
  localparam int CW = (BURST_MAX > 2) ? $clog2(BURST_MAX) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic step_i,
  output logic done_o
);
  logic [CW-1:0] cnt_q, cnt_d;

  assign done_o = step_i && (cnt_q == CW'(BURST_MAX - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (done_o) cnt_d = '0;
    else if (step_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dsd_irq_latch.sv
module dsd_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic ack_i,
  output logic irq_o
);
  logic irq_q, irq_d;
  assign irq_d = set_i | (irq_q & ~ack_i);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end
  assign irq_o = irq_q;
endmodule

// File: rtl/dsd_engine.sv
module dsd_engine
  import dsd_pkg::*;
#(
  parameter int AW        = 32,
  parameter int BURST_MAX = 2048
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable_i,
  input  logic          stop_i,
  input  logic          start_i,
  input  logic          cont_i,
  input  logic [AW-1:0] head_ptr_i,
  input  logic [AW-1:0] ctx_ptr_i,
  input  logic          intr_ack_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          st_valid_o,
  output logic [7:0]    st_data_o,
  output logic          st_last_o,
  input  logic          st_ready_i,
  output logic          busy_o,
  output logic          running_o,
  output logic          eol_o,
  output logic          intr_o,
  output logic [AW-1:0] buf_ptr_o,
  output logic [AW-1:0] desc_ptr_o
);
  localparam int IW = $clog2(DESC_WORDS);
  localparam logic [AW-1:0] OFS_FLAGS = AW'(8);
  localparam logic [AW-1:0] OFS_CTX   = AW'(4 * CTX_FLAGS_WORD);

  dsd_state_e    st_q, st_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [AW-1:0] dptr_q, dptr_d, ctx_q, ctx_d, nxt_q, nxt_d;
  logic [AW-1:0] bstart_q, bstart_d, bend_q, bend_d, ptr_q, ptr_d, mir_q, mir_d;
  logic [31:0]   flags_q, flags_d, word_q, word_d;
  logic          eol_q, eol_d, run_q, run_d, cont_q, cont_d;

  logic          hs, end_hit, burst_done, fin, start_ok, cont_ok;
  logic [AW-1:0] ptr_inc;
  logic [7:0]    lane_byte;

  assign ptr_inc  = ptr_q + 1'b1;
  assign hs       = (st_q == S_PUSH) && st_ready_i;
  assign end_hit  = (ptr_inc == bend_q);
  assign fin      = ((st_q == S_CHECK) && (ptr_q == bend_q)) || (hs && end_hit);
  assign start_ok = start_i && enable_i && !stop_i;
  assign cont_ok  = cont_i && enable_i && !stop_i && run_q && eol_q && flags_q[FL_EOL];

  dsd_lane_sel #(.LANES(4)) u_lane (
    .word_i (word_q), .sel_i (ptr_q[1:0]), .byte_o (lane_byte)
  );

  dsd_burst_ctr #(.BURST_MAX(BURST_MAX)) u_burst (
    .clk (clk), .rst_n (rst_n), .clr_i (st_q == S_CHECK),
    .step_i (hs), .done_o (burst_done)
  );

  dsd_irq_latch u_irq (
    .clk (clk), .rst_n (rst_n), .set_i (fin && flags_q[FL_INTR]),
    .ack_i (intr_ack_i), .irq_o (intr_o)
  );

  always_comb begin
    st_d = st_q;  idx_d = idx_q;  dptr_d = dptr_q;  ctx_d = ctx_q;
    nxt_d = nxt_q;  bstart_d = bstart_q;  bend_d = bend_q;  ptr_d = ptr_q;
    mir_d = mir_q;  flags_d = flags_q;  word_d = word_q;
    eol_d = eol_q;  run_d = run_q;  cont_d = cont_q;
    mem_req_o = 1'b0;  mem_we_o = 1'b0;  mem_addr_o = '0;  mem_wdata_o = '0;
    unique case (st_q)
      S_IDLE: begin
        if (start_ok) begin
          dptr_d = head_ptr_i;  ctx_d = ctx_ptr_i;  eol_d = 1'b0;
          run_d = 1'b1;  cont_d = 1'b0;  idx_d = '0;  st_d = S_FETCH;
        end else if (cont_ok) begin
          cont_d = 1'b1;  idx_d = '0;  st_d = S_FETCH;
        end
      end
      S_FETCH: begin
        mem_req_o  = 1'b1;
        mem_addr_o = dptr_q + AW'({idx_q, 2'b00});
        if (mem_ack_i) begin
          idx_d = idx_q + 1'b1;
          unique case (idx_q)
            2'd0: nxt_d    = AW'(mem_rdata_i);
            2'd1: bstart_d = AW'(mem_rdata_i);
            2'd2: flags_d  = mem_rdata_i;
            default: bend_d = AW'(mem_rdata_i);
          endcase
          if (idx_q == IW'(DESC_WORDS - 1)) begin
            if (cont_q && flags_q[FL_EOL]) begin
              cont_d = 1'b0;  st_d = S_IDLE;
            end else if (cont_q) begin
              cont_d = 1'b0;  eol_d = 1'b0;  dptr_d = nxt_q;
            end else begin
              ptr_d = bstart_q;  mir_d = bstart_q;  st_d = S_CHECK;
            end
          end
        end
      end
      S_CHECK: st_d = (ptr_q == bend_q) ? S_WB : S_RD;
      S_RD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = {ptr_q[AW-1:2], 2'b00};
        if (mem_ack_i) begin
          word_d = mem_rdata_i;  st_d = S_PUSH;
        end
      end
      S_PUSH: begin
        if (hs) begin
          ptr_d = ptr_inc;
          if (end_hit || burst_done) mir_d = ptr_inc;
          if (end_hit)                 st_d = S_WB;
          else if (ptr_inc[1:0] == 2'b00) st_d = S_RD;
        end
      end
      S_WB: begin
        mem_req_o = 1'b1;  mem_we_o = 1'b1;
        mem_addr_o = dptr_q + OFS_FLAGS;  mem_wdata_o = flags_q;
        if (mem_ack_i) begin
          if (flags_q[FL_EOL]) begin
            eol_d = 1'b1;  st_d = S_CTX_RD;
          end else begin
            dptr_d = nxt_q;  idx_d = '0;  st_d = S_FETCH;
          end
        end
      end
      S_CTX_RD: begin
        mem_req_o = 1'b1;  mem_addr_o = ctx_q + OFS_CTX;
        if (mem_ack_i) begin
          word_d = mem_rdata_i | (32'd1 << CTX_DIS);  st_d = S_CTX_WR;
        end
      end
      S_CTX_WR: begin
        mem_req_o = 1'b1;  mem_we_o = 1'b1;
        mem_addr_o = ctx_q + OFS_CTX;  mem_wdata_o = word_q;
        if (mem_ack_i) st_d = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
    if (!enable_i || stop_i) run_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;  idx_q <= '0;  dptr_q <= '0;  ctx_q <= '0;
      nxt_q <= '0;  bstart_q <= '0;  bend_q <= '0;  ptr_q <= '0;
      mir_q <= '0;  flags_q <= '0;  word_q <= '0;
      eol_q <= 1'b0;  run_q <= 1'b0;  cont_q <= 1'b0;
    end else begin
      st_q <= st_d;  idx_q <= idx_d;  dptr_q <= dptr_d;  ctx_q <= ctx_d;
      nxt_q <= nxt_d;  bstart_q <= bstart_d;  bend_q <= bend_d;  ptr_q <= ptr_d;
      mir_q <= mir_d;  flags_q <= flags_d;  word_q <= word_d;
      eol_q <= eol_d;  run_q <= run_d;  cont_q <= cont_d;
    end
  end

  assign st_valid_o = (st_q == S_PUSH);
  assign st_data_o  = lane_byte;
  assign st_last_o  = st_valid_o && flags_q[FL_OEOP] && end_hit;
  assign busy_o     = (st_q != S_IDLE);
  assign running_o  = run_q;
  assign eol_o      = eol_q;
  assign buf_ptr_o  = mir_q;
  assign desc_ptr_o = dptr_q;
endmodule

// File: rtl/dsd_engine_chk.sv
module dsd_engine_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable_i,
  input logic          stop_i,
  input logic          intr_ack_i,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [31:0]   mem_wdata_o,
  input logic          mem_ack_i,
  input logic          st_valid_o,
  input logic [7:0]    st_data_o,
  input logic          st_last_o,
  input logic          st_ready_i,
  input logic          busy_o,
  input logic          running_o,
  input logic          eol_o,
  input logic          intr_o
);
  // R10
  stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid_o && !st_ready_i |=> st_valid_o && $stable(st_data_o) && $stable(st_last_o));
  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                && $stable(mem_wdata_o));
  // R10
  no_mem_while_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid_o |-> !mem_req_o);
  // R8
  idle_at_eol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> eol_o);
  // R5
  intr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intr_o && intr_ack_i && !busy_o |=> !intr_o);
  // R13
  run_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable_i || stop_i) |=> !running_o);
endmodule

bind dsd_engine dsd_engine_chk #(.AW(AW)) u_chk (.*);

// File: tb/dsd_engine_bench.sv
module dsd_engine_bench;
  localparam int AW = 32;
  localparam int BM = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enable_i = 1'b0, stop_i = 1'b0, start_i = 1'b0, cont_i = 1'b0, intr_ack_i = 1'b0;
  logic [AW-1:0] head_ptr_i = '0, ctx_ptr_i = '0;
  logic mem_req_o, mem_we_o, mem_ack_i = 1'b0;
  logic [AW-1:0] mem_addr_o;
  logic [31:0] mem_wdata_o, mem_rdata_i = '0;
  logic st_valid_o, st_last_o, st_ready_i = 1'b0;
  logic [7:0] st_data_o;
  logic busy_o, running_o, eol_o, intr_o;
  logic [AW-1:0] buf_ptr_o, desc_ptr_o;

  always #10 clk = ~clk;

  dsd_engine #(.AW(AW), .BURST_MAX(BM)) u_dsd_engine (.*);

  int checks = 0, fails = 0;
  logic [31:0] mem [256];
  logic [7:0]  cap_b [64];
  logic        cap_l [64];
  int          cap_n = 0;
  logic [31:0] mir [32];
  int          mir_n = 0;
  logic [31:0] wlog_a [16];
  logic [31:0] wlog_d [16];
  int          wn = 0;
  bit rnd_ready = 0, busy_seen = 0, eol_low_seen = 0, logging = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [7:0] bval(input int a);
    return 8'((a * 13 + 5) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder and stream sink, both acting at the falling edge
  always @(negedge clk) begin
    if (mem_req_o && !mem_ack_i) begin
      mem_ack_i = 1'b1;
      if (mem_we_o) begin
        mem[mem_addr_o[9:2]] = mem_wdata_o;
        if (wn < 16) begin wlog_a[wn] = mem_addr_o; wlog_d[wn] = mem_wdata_o; end
        wn++;
      end else mem_rdata_i = mem[mem_addr_o[9:2]];
    end else mem_ack_i = 1'b0;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    st_ready_i = rnd_ready ? lfsr[0] : 1'b1;
    if (st_valid_o && st_ready_i && cap_n < 64) begin
      cap_b[cap_n] = st_data_o; cap_l[cap_n] = st_last_o; cap_n++;
    end
    if (busy_o) busy_seen = 1;
    if (!eol_o) eol_low_seen = 1;
    if (logging && (mir_n == 0 || mir[mir_n-1] != buf_ptr_o) && mir_n < 32) begin
      mir[mir_n] = buf_ptr_o; mir_n++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic clear_logs();
    cap_n = 0; mir_n = 0; wn = 0; busy_seen = 0; eol_low_seen = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy_o && n < 3000) begin @(negedge clk); n++; end
    if (n >= 3000) chk(0, "watchdog", 32'd1, 32'd0);
  endtask

  task automatic pulse_start(input logic [31:0] head);
    @(negedge clk);
    head_ptr_i = head; ctx_ptr_i = 32'h20; start_i = 1'b1; logging = 1;
    @(negedge clk);
    start_i = 1'b0;
    wait_idle();
    logging = 0;
  endtask

  task automatic pulse_cont();
    @(negedge clk); cont_i = 1'b1;
    @(negedge clk); cont_i = 1'b0;
    wait_idle();
  endtask

  task automatic ack_intr();
    @(negedge clk); intr_ack_i = 1'b1;
    @(negedge clk); intr_ack_i = 1'b0;
  endtask

  task automatic put_desc(input int a, input logic [31:0] nx, input logic [31:0] s,
                          input logic [31:0] fl, input logic [31:0] e);
    mem[a/4] = nx; mem[a/4+1] = s; mem[a/4+2] = fl; mem[a/4+3] = e;
  endtask

  initial begin
    for (int w = 0; w < 256; w++)
      mem[w] = {bval(4*w+3), bval(4*w+2), bval(4*w+1), bval(4*w)};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({busy_o, running_o, eol_o, intr_o, st_valid_o, mem_req_o} == 6'b0, "R1", 
        {26'd0, busy_o, running_o, eol_o, intr_o, st_valid_o, mem_req_o}, 32'd0);
    rst_n = 1'b1; enable_i = 1'b1;
    @(negedge clk);
    chk({busy_o, running_o, eol_o, intr_o} == 4'b0, "R1 after release",
        {28'd0, busy_o, running_o, eol_o, intr_o}, 32'd0);

    // sweep: every start offset against lengths 0..9
    for (int off = 0; off < 4; off++) begin
      for (int len = 0; len < 10; len++) begin
        automatic int s = 32'h100 + off;
        automatic bit oe = ((off + len) % 2) == 1;
        automatic bit it = (len % 3) == 0;
        automatic logic [31:0] fl = 32'h1 | (oe ? 32'h8 : 0) | (it ? 32'h10 : 0) | 32'h00A5_0000;
        automatic bit ok;
        automatic logic [31:0] e [8];
        automatic int en = 0;
        rnd_ready = (len % 2) == 1;
        put_desc(32'h40, 32'h80, s, fl, s + len);
        mem[9] = 32'h0000_00A5;
        clear_logs();
        pulse_start(32'h40);
        // R2 / R3 bytes
        ok = (cap_n == len);
        for (int k = 0; k < cap_n && k < len; k++) if (cap_b[k] != bval(s + k)) ok = 0;
        chk(ok, len == 0 ? "R3 empty buffer" : "R2 bytes", cap_n, len);
        // R4 last flag
        ok = 1;
        for (int k = 0; k < cap_n; k++) if (cap_l[k] != (oe && k == len - 1)) ok = 0;
        chk(ok, "R4 last", {31'd0, oe}, {31'd0, ok});
        // R5 interrupt
        chk(intr_o == it, "R5 intr", {31'd0, intr_o}, {31'd0, it});
        ack_intr();
        chk(intr_o == 1'b0, "R5 ack", {31'd0, intr_o}, 32'd0);
        // R6 write-back of flags
        chk(wn == 2 && wlog_a[0] == 32'h48 && wlog_d[0] == fl, "R6 writeback", wlog_a[0], 32'h48);
        // R8 context disable
        chk(mem[9] == 32'h0000_80A5 && eol_o && running_o, "R8 context", mem[9], 32'h0000_80A5);
        // R9 mirror sequence
        e[en++] = s;
        for (int k = BM; k < len; k += BM) e[en++] = s + k;
        if (len > 0) e[en++] = s + len;
        ok = (mir_n >= en) && (mir_n <= en + 1);
        for (int k = 0; k < en && ok; k++) if (mir[mir_n - en + k] != e[k]) ok = 0;
        chk(ok, "R9 mirror", mir_n > 0 ? mir[mir_n-1] : 32'hx, e[en-1]);
      end
    end

    // R7 chain of three with an empty middle buffer
    rnd_ready = 1;
    put_desc(32'h40, 32'h60, 32'h200, 32'h0, 32'h205);
    put_desc(32'h60, 32'h80, 32'h210, 32'h10, 32'h210);
    put_desc(32'h80, 32'hA0, 32'h223, 32'h19, 32'h229);
    mem[9] = 32'h0000_00A5;
    clear_logs();
    pulse_start(32'h40);
    begin
      automatic bit ok = (cap_n == 11);
      for (int k = 0; k < 5; k++) if (cap_b[k] != bval(32'h200 + k) || cap_l[k]) ok = 0;
      for (int k = 0; k < 6; k++) if (cap_b[5+k] != bval(32'h223 + k) || cap_l[5+k] != (k == 5)) ok = 0;
      chk(ok, "R7 chain bytes", cap_n, 32'd11);
    end
    chk(wn == 4 && wlog_a[0] == 32'h48 && wlog_a[1] == 32'h68 && wlog_a[2] == 32'h88 && wlog_a[3] == 32'h24,
        "R6 chain writebacks", wn, 32'd4);
    chk(intr_o == 1'b1 && desc_ptr_o == 32'h80, "R7 chain end", desc_ptr_o, 32'h80);
    ack_intr();

    // R11 continue with end mark still set: refetch, stay halted
    put_desc(32'hA0, 32'hC0, 32'h300, 32'h1, 32'h303);
    clear_logs();
    pulse_cont();
    chk(busy_seen && cap_n == 0 && eol_o && wn == 0, "R11 cont still eol", cap_n, 32'd0);
    // R12 continue after clearing the mark
    mem[32'h88/4] = 32'h18;
    mem[9] = 32'h0000_00A5;
    clear_logs();
    pulse_cont();
    begin
      automatic bit ok = (cap_n == 3);
      for (int k = 0; k < 3 && k < cap_n; k++) if (cap_b[k] != bval(32'h300 + k)) ok = 0;
      chk(ok, "R12 cont streams next", cap_n, 32'd3);
    end
    chk(eol_low_seen && eol_o && desc_ptr_o == 32'hA0 && mem[9] == 32'h0000_80A5,
        "R12 cont advance", desc_ptr_o, 32'hA0);

    // R11 continue ignored under stop; R13 stop clears running
    @(negedge clk); stop_i = 1'b1;
    @(negedge clk);
    chk(running_o == 1'b0, "R13 stop drops running", {31'd0, running_o}, 32'd0);
    clear_logs();
    pulse_cont();
    repeat (6) @(negedge clk);
    chk(!busy_seen, "R11 cont under stop", {31'd0, busy_seen}, 32'd0);
    // R13 start ignored while disabled
    stop_i = 1'b0; enable_i = 1'b0;
    clear_logs();
    pulse_start(32'h40);
    repeat (6) @(negedge clk);
    chk(!busy_seen && !running_o && eol_o, "R13 start gated", {31'd0, busy_seen}, 32'd0);
    // R13 start clears eol and sets running
    enable_i = 1'b1;
    put_desc(32'h40, 32'h60, 32'h100, 32'h1, 32'h102);
    clear_logs();
    pulse_start(32'h40);
    chk(eol_low_seen && running_o && cap_n == 2, "R13 start", cap_n, 32'd2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule